// File: doc/BRIEF.md
# Beam-Crossing Timing Marker Generator

This block derives a crate's timing markers from one fast reference clock. It divides the reference by eight to form the tick clock. It raises a begin-of-turn marker for one tick period at the start of every turn, where a turn is 128 or 256 ticks long. It also drives a live-crossing level that is always defined and toggles at a programmable fraction of the tick rate. Every output leaves a register clocked on the fast clock. The two control markers are phase-placed two fast cycles after the tick clock's rising edge, so downstream receivers latching on that edge see them settled.

The turn length and the toggle divisor are plain configuration levels. The block copies them into shadow registers during reset and again at each turn boundary, so a change made mid-turn never breaks the current turn. There is no streaming data path, so the block has no valid/ready handshake.

Top module: `bx_marker_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `tick_clk`, `turn_mark` and `live_mark` are all 0 after that edge, all internal counters restart, and the current `turn_sel` and `tog_div` are captured as the active configuration.
- R2: `tick_clk` is high for four fast cycles and then low for four, repeating. It becomes 1 at the first clock edge after `rst` falls.
- R3: `turn_mark` is high for exactly eight fast cycles (one tick period) once per turn. A turn is 128 ticks when the active select is 0 and 256 ticks when it is 1. The first turn begins with the first tick after reset.
- R4: `turn_mark` and `live_mark` change only at the clock edge two fast cycles after a `tick_clk` rising edge.
- R5: `live_mark` is 0 after reset. At the marker update of tick k of a turn (k counted from 0), it inverts when k mod N equals N-1, where N is the active divisor. The divisor count restarts at every turn boundary.
- R6: An active divisor of 0 behaves as a divisor of 1, so the live marker toggles on every tick.
- R7: Changes on `turn_sel` or `tog_div` during a turn take effect only from the first tick of the following turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| turn_sel | input | 1 | Turn length select: 0 gives 128 ticks, 1 gives 256 ticks |
| tog_div | input | DIV_W | Live-marker divisor N, in tick periods (0 is taken as 1) |
| tick_clk | output | 1 | Tick clock, the reference divided by eight, 50% duty |
| turn_mark | output | 1 | Begin-of-turn marker, high for one tick period per turn |
| live_mark | output | 1 | Live-crossing toggle level |

## Verification
On every cycle, the assertions pin the phase of every output edge to the divide-by-eight counter. They check that the tick clock rises and falls at fixed phases and that the markers move only in the slot two cycles after a tick rise. They also check that the turn marker rises only on the first tick of a turn and that the shadowed configuration never moves except at a turn boundary. The bench's scenarios are needed to show the parts that depend on whole turns: the 128- and 256-tick turn lengths, the toggle pattern for several divisors including realignment where the turn length is not a multiple of N, the zero-divisor case, the one-turn delay before a configuration change applies, and configuration captured during a mid-run reset.

// File: rtl/bxm_pkg.sv
package bxm_pkg;
  // Default geometry of the generator
  localparam int DEF_PH_W        = 3;    // divide-by-8 phase counter
  localparam int DEF_MARK_OFS    = 2;    // marker slot after tick rise
  localparam int DEF_DIV_W       = 8;
  localparam int DEF_SHORT_TICKS = 128;
  localparam int DEF_LONG_TICKS  = 256;

  typedef enum logic {
    TURN_SHORT = 1'b0,
    TURN_LONG  = 1'b1
  } turn_len_e;
endpackage

// File: rtl/bxm_phase.sv
module bxm_phase #(
  parameter int PH_W     = bxm_pkg::DEF_PH_W,
  parameter int MARK_OFS = bxm_pkg::DEF_MARK_OFS
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph,
  output logic            tick_hi,
  output logic            tick_end,
  output logic            mark_slot
);
  localparam int PHASES = 1 << PH_W;
  localparam int HALF   = PHASES / 2;
  localparam int LAST   = PHASES - 1;

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else     ph <= ph + 1'b1;
  end

  assign tick_hi   = (ph < PH_W'(HALF));
  assign tick_end  = (ph == PH_W'(LAST));
  assign mark_slot = (ph == PH_W'(MARK_OFS));

  // R2: the phase counter wraps to zero after its last phase
  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_W'(LAST)) |=> (ph == '0));
endmodule

// File: rtl/bxm_turn_ctr.sv
module bxm_turn_ctr #(
  parameter int DIV_W       = bxm_pkg::DEF_DIV_W,
  parameter int SHORT_TICKS = bxm_pkg::DEF_SHORT_TICKS,
  parameter int LONG_TICKS  = bxm_pkg::DEF_LONG_TICKS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_end,
  input  logic             turn_sel,
  input  logic [DIV_W-1:0] tog_div,
  output logic             first_tick,
  output logic             live_hit,
  output logic             turn_end
);
  import bxm_pkg::*;
  localparam int TC_W = $clog2(LONG_TICKS);

  logic [TC_W-1:0]  tcnt;
  logic [TC_W-1:0]  turn_last;
  turn_len_e        act_len;
  logic [DIV_W-1:0] act_div;
  logic [DIV_W-1:0] lcnt;
  logic [DIV_W-1:0] div_fix;

  // zero divisor behaves as one
  assign div_fix    = (tog_div == '0) ? DIV_W'(1) : tog_div;
  assign turn_last  = (act_len == TURN_LONG) ? TC_W'(LONG_TICKS - 1)
                                             : TC_W'(SHORT_TICKS - 1);
  assign turn_end   = tick_end && (tcnt == turn_last);
  assign first_tick = (tcnt == '0);
  assign live_hit   = (lcnt == act_div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt    <= '0;
      lcnt    <= '0;
      act_len <= turn_len_e'(turn_sel);
      act_div <= div_fix;
    end else if (turn_end) begin
      tcnt    <= '0;
      lcnt    <= '0;
      act_len <= turn_len_e'(turn_sel);
      act_div <= div_fix;
    end else if (tick_end) begin
      tcnt <= tcnt + 1'b1;
      lcnt <= live_hit ? '0 : lcnt + 1'b1;
    end
  end

  // R7: shadowed configuration moves only at a turn boundary
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !turn_end |=> ($stable(act_len) && $stable(act_div)));

  // R5: divisor count stays inside the active divisor
  a_r5_lcnt_range: assert property (@(posedge clk) disable iff (rst)
    tick_end |=> (lcnt < act_div));
endmodule

// File: rtl/bxm_out_regs.sv
module bxm_out_regs (
  input  logic clk,
  input  logic rst,
  input  logic tick_hi,
  input  logic mark_slot,
  input  logic first_tick,
  input  logic live_hit,
  output logic tick_q,
  output logic turn_q,
  output logic live_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
      turn_q <= 1'b0;
      live_q <= 1'b0;
    end else begin
      tick_q <= tick_hi;
      if (mark_slot) begin
        turn_q <= first_tick;
        if (live_hit) live_q <= ~live_q;
      end
    end
  end
endmodule

// File: rtl/bx_marker_gen.sv
module bx_marker_gen #(
  parameter int PH_W        = bxm_pkg::DEF_PH_W,
  parameter int MARK_OFS    = bxm_pkg::DEF_MARK_OFS,
  parameter int DIV_W       = bxm_pkg::DEF_DIV_W,
  parameter int SHORT_TICKS = bxm_pkg::DEF_SHORT_TICKS,
  parameter int LONG_TICKS  = bxm_pkg::DEF_LONG_TICKS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             turn_sel,
  input  logic [DIV_W-1:0] tog_div,
  output logic             tick_clk,
  output logic             turn_mark,
  output logic             live_mark
);
  localparam int HALF = (1 << PH_W) / 2;

  logic [PH_W-1:0] ph;
  logic tick_hi, tick_end, mark_slot;
  logic first_tick, live_hit, turn_end;

  bxm_phase #(.PH_W(PH_W), .MARK_OFS(MARK_OFS)) u_phase (
    .clk(clk), .rst(rst), .ph(ph), .tick_hi(tick_hi),
    .tick_end(tick_end), .mark_slot(mark_slot)
  );

  bxm_turn_ctr #(.DIV_W(DIV_W), .SHORT_TICKS(SHORT_TICKS),
                 .LONG_TICKS(LONG_TICKS)) u_turn (
    .clk(clk), .rst(rst), .tick_end(tick_end), .turn_sel(turn_sel),
    .tog_div(tog_div), .first_tick(first_tick), .live_hit(live_hit),
    .turn_end(turn_end)
  );

  bxm_out_regs u_out (
    .clk(clk), .rst(rst), .tick_hi(tick_hi), .mark_slot(mark_slot),
    .first_tick(first_tick), .live_hit(live_hit),
    .tick_q(tick_clk), .turn_q(turn_mark), .live_q(live_mark)
  );

  // R2: tick edges sit at fixed phases of the counter
  a_r2_tick_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(tick_clk) |-> (ph == PH_W'(1)));
  a_r2_tick_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(tick_clk) |-> (ph == PH_W'(HALF + 1)));
  // R4: markers move only in the slot after a tick rise
  a_r4_turn_slot: assert property (@(posedge clk) disable iff (rst)
    !$stable(turn_mark) |-> (ph == PH_W'(MARK_OFS + 1)));
  a_r4_live_slot: assert property (@(posedge clk) disable iff (rst)
    !$stable(live_mark) |-> (ph == PH_W'(MARK_OFS + 1)));
  // R3: turn marker rises only on the first tick of a turn
  a_r3_turn_first: assert property (@(posedge clk) disable iff (rst)
    $rose(turn_mark) |-> first_tick);
endmodule

// File: tb/bx_marker_gen_tb.sv
module bx_marker_gen_tb;
  typedef struct {
    bit    turn;
    bit    live;
    string note;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst;
  logic       turn_sel;
  logic [7:0] tog_div;
  logic       tick_clk, turn_mark, live_mark;

  int checks = 0;
  int errors = 0;
  int n = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  bit last_turn = 1'b0;
  bit last_live = 1'b0;
  bit live_exp = 1'b0;
  bit lat_sel;
  int lat_div;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  bx_marker_gen u_dut (
    .clk(clk), .rst(rst), .turn_sel(turn_sel), .tog_div(tog_div),
    .tick_clk(tick_clk), .turn_mark(turn_mark), .live_mark(live_mark)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // edges since reset release
  always @(posedge clk) begin
    if (rst) n <= 0;
    else     n <= n + 1;
  end

  // monitor: compares outputs after each edge
  always @(negedge clk) begin
    if (rst) begin
      last_turn = 1'b0;
      last_live = 1'b0;
    end else if (mon_on && n > 0) begin
      chk(tick_clk == (((n - 1) % 8) < 4), "R2 tick_clk", int'(tick_clk),
          int'(((n - 1) % 8) < 4));
      if (((n - 1) % 8) == 2) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 scoreboard empty", 0, 1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(turn_mark == e.turn, {"R3 turn_mark ", e.note}, int'(turn_mark), int'(e.turn));
          chk(live_mark == e.live, {"R5 live_mark ", e.note}, int'(live_mark), int'(e.live));
          last_turn = e.turn;
          last_live = e.live;
        end
      end else begin
        chk(turn_mark == last_turn, "R4 turn_mark off slot", int'(turn_mark), int'(last_turn));
        chk(live_mark == last_live, "R4 live_mark off slot", int'(live_mark), int'(last_live));
      end
    end
  end

  // driver: one turn with the latched config, then queue the next config
  task automatic run_turn(input bit nsel, input logic [7:0] ndiv, input string note);
    int len;
    int nd;
    len = lat_sel ? 256 : 128;
    nd  = (lat_div == 0) ? 1 : lat_div;   // R6 zero as one
    for (int k = 0; k < len; k++) begin
      exp_t e;
      if ((k % nd) == nd - 1) live_exp = ~live_exp;
      e.turn = (k == 0);
      e.live = live_exp;
      e.note = note;
      exp_q.push_back(e);
    end
    turn_sel = nsel;        // R7 mid-turn change
    tog_div  = ndiv;
    repeat (len * 8) @(negedge clk);
    lat_sel = nsel;
    lat_div = int'(ndiv);
  endtask

  task automatic reset_checks();
    chk(tick_clk == 1'b0, "R1 tick_clk in reset", int'(tick_clk), 0);
    chk(turn_mark == 1'b0, "R1 turn_mark in reset", int'(turn_mark), 0);
    chk(live_mark == 1'b0, "R1 live_mark in reset", int'(live_mark), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    turn_sel = 1'b0;
    tog_div = 8'd1;
    repeat (3) @(negedge clk);
    reset_checks();
    lat_sel = 1'b0;
    lat_div = 1;
    live_exp = 1'b0;
    rst = 1'b0;
    mon_on = 1'b1;
    run_turn(1'b0, 8'd3, "R3 short turn divisor 1");
    run_turn(1'b1, 8'd0, "R5 divisor 3 realigns at boundary");
    run_turn(1'b1, 8'd5, "R3 R6 long turn zero divisor");
    run_turn(1'b0, 8'd2, "R7 long turn divisor 5");
    run_turn(1'b0, 8'd2, "R7 short turn divisor 2");
    // mid-run reset with new config applied during reset
    rst = 1'b1;
    mon_on = 1'b0;
    turn_sel = 1'b1;
    tog_div = 8'd3;
    repeat (3) @(negedge clk);
    reset_checks();
    exp_q.delete();
    lat_sel = 1'b1;
    lat_div = 3;
    live_exp = 1'b0;
    rst = 1'b0;
    mon_on = 1'b1;
    run_turn(1'b0, 8'd1, "R1 config captured in reset");
    run_turn(1'b0, 8'd1, "R5 short turn after reset");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule